// File: doc/BRIEF.md
# Bypassable DC-Removal High-Pass Filter

This block removes a constant offset from one channel of signed 24-bit audio. Each accepted sample goes through a first-order recursive filter. The filter has a zero at DC and a pole just inside the unit circle, so a steady input level fades toward zero while the audible band passes almost untouched. A chip places one copy of the block per channel, after the decimation stage and ahead of the serial output formatter.

The pole multiply is replaced by a shift and a subtract: the feedback term is `y - (y >>> 11)`, which gives a pole of about 0.99951. The feedback state keeps 8 fractional bits below the output LSB, which limits truncation error. A bypass input selects plain pass-through. In bypass, a sample appears unchanged at the output with the same one-cycle latency as a filtered sample, and the filter memory is cleared.

Top module: `dc_block_hpf`

## Requirements
- R1: While `rstN` is low and until the first accepted sample, `outValid` is 0 and `outData` is 0; the filter memory (previous input and feedback accumulator) resets to zero.
- R2: `outValid` is 1 in exactly the cycle after a cycle with `inValid` high, and 0 otherwise.
- R3: With `bypass` = 0, an accepted sample x updates the filter memory (previous input p, accumulator A with 8 fractional bits) as S = ((x − p)·256) + A − floor(A / 2048) and A ← S, p ← x.
- R4: The output of a filtered sample is floor(A / 256) of the new accumulator, which truncates toward minus infinity.
- R5: If S exceeds the 32-bit signed range, A takes the range limit (2^31 − 1 or −2^31). The output is then 8388607 or −8388608 and never wraps.
- R6: With `bypass` = 1, an accepted sample appears unchanged on `outData` one cycle later.
- R7: A bypassed sample clears p and A to zero. The next filtered sample x therefore outputs exactly x.
- R8: In cycles without `inValid`, `outData` and the filter memory hold their values, whatever `inData` and `bypass` do.
- R9: A constant input stream decays. Starting from cleared memory with a constant input of 1000000, the output magnitude is below 256 after 20000 samples.
- R10: The value of `bypass` in the cycle `inValid` is high selects the mode for that sample. A change of `bypass` on that same cycle takes effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe for `inData` |
| inData | input | 24 | Signed input sample |
| bypass | input | 1 | 1 = pass samples unchanged, 0 = filter |
| outValid | output | 1 | Strobe for `outData`, one cycle after `inValid` |
| outData | output | 24 | Signed output sample, held between strobes |

## Verification
A mode change and a sample can arrive in the same cycle. The same holds for leaving bypass and the first filtered sample, whose expected value depends on the memory that bypass cleared. The bench provokes both by toggling `bypass` at random on the same cycles as `inValid`. It also runs a directed sequence: a bypassed sample, then a full-scale negative filtered sample, then a full-scale positive one, which forces saturation straight after the clear. Each output is judged against a bench model that applies the recurrence, the clear and the clamp in the mode sampled at that strobe.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

  // Strobes issued by the control to the datapath for one accepted sample
  typedef struct packed {
    logic load;  // filter the sample and advance the memory
    logic pass;  // forward the sample unchanged and clear the memory
  } hpf_strobe_t;

endpackage

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
  import hpf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        bypass,
  output hpf_strobe_t strobe,
  output logic        outValid
);

  // Mode is taken from bypass in the same cycle as the strobe (R10)
  always_comb begin
    strobe.load = inValid & ~bypass;
    strobe.pass = inValid &  bypass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: the output strobe trails each input strobe by exactly one cycle
  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R10: at most one datapath action per cycle
  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.pass}));

endmodule

// File: rtl/hpf_datapath.sv
module hpf_datapath
  import hpf_pkg::*;
#(
  parameter int DW         = 24,
  parameter int FRAC       = 8,
  parameter int POLE_SHIFT = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hpf_strobe_t          strobe,
  input  logic signed [DW-1:0] inData,
  output logic signed [DW-1:0] outData
);

  localparam int ACCW = DW + FRAC;   // accumulator width
  localparam int SUMW = ACCW + 2;    // headroom for the unclamped sum

  localparam logic signed [SUMW-1:0] ACC_MAX = {{3{1'b0}}, {(ACCW-1){1'b1}}};
  localparam logic signed [SUMW-1:0] ACC_MIN = {{3{1'b1}}, {(ACCW-1){1'b0}}};
  localparam logic signed [DW-1:0]   OUT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0]   OUT_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0]   xPrev;
  logic signed [ACCW-1:0] yAcc;

  logic signed [DW:0]     diff;
  logic signed [SUMW-1:0] diffScaled;
  logic signed [SUMW-1:0] yExt;
  logic signed [SUMW-1:0] feedback;
  logic signed [SUMW-1:0] sum;
  logic                   sumHi;
  logic                   sumLo;
  logic signed [ACCW-1:0] yNext;

  // Zero at DC: first difference of the input (R3)
  always_comb begin
    diff       = {inData[DW-1], inData} - {xPrev[DW-1], xPrev};
    diffScaled = {{(SUMW-DW-1){diff[DW]}}, diff} <<< FRAC;
  end

  // Pole: y - y/2^POLE_SHIFT, arithmetic shift floors (R3)
  always_comb begin
    yExt     = {{(SUMW-ACCW){yAcc[ACCW-1]}}, yAcc};
    feedback = yExt - (yExt >>> POLE_SHIFT);
    sum      = diffScaled + feedback;
  end

  // Clamp to the accumulator range instead of wrapping (R5)
  always_comb begin
    sumHi = (sum > ACC_MAX);
    sumLo = (sum < ACC_MIN);
    if (sumHi)      yNext = ACC_MAX[ACCW-1:0];
    else if (sumLo) yNext = ACC_MIN[ACCW-1:0];
    else            yNext = sum[ACCW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPrev   <= '0;
      yAcc    <= '0;
      outData <= '0;
    end else if (strobe.pass) begin
      xPrev   <= '0;                       // R7
      yAcc    <= '0;
      outData <= inData;                   // R6
    end else if (strobe.load) begin
      xPrev   <= inData;
      yAcc    <= yNext;
      outData <= yNext[ACCW-1:FRAC];       // R4: floor of fixed point
    end
  end

  // R5: an overflowing sum pins the output to the positive limit
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && sumHi) |=> (outData == OUT_MAX));

  // R5: an underflowing sum pins the output to the negative limit
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && sumLo) |=> (outData == OUT_MIN));

  // R6: bypassed samples leave unchanged
  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pass |=> (outData == $past(inData)));

  // R7: bypass leaves the filter memory empty
  assert_bypass_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pass |=> (yAcc == '0 && xPrev == '0));

  // R8: no strobe, no change
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.pass) |=> ($stable(outData) && $stable(yAcc) && $stable(xPrev)));

endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
  import hpf_pkg::*;
#(
  parameter int DW         = 24,
  parameter int FRAC       = 8,
  parameter int POLE_SHIFT = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inData,
  input  logic                 bypass,
  output logic                 outValid,
  output logic signed [DW-1:0] outData
);

  hpf_strobe_t strobe;

  hpf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bypass   (bypass),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hpf_datapath #(
    .DW         (DW),
    .FRAC       (FRAC),
    .POLE_SHIFT (POLE_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

  // R1/R2: output strobe never appears without a prior input strobe
  assert_out_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

endmodule

// File: tb/sim_dc_block_hpf.sv
module sim_dc_block_hpf;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [23:0] inData = '0;
  logic               bypass = 1'b0;
  logic               outValid;
  logic signed [23:0] outData;

  int testsRun = 0;
  int testsFailed = 0;

  // Reference memory: previous input and accumulator with 8 fraction bits
  longint mX = 0;
  longint mY = 0;
  logic signed [23:0] lastOut = '0;

  always #10 clk = ~clk;   // 50 MHz

  dc_block_hpf u0 (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .bypass   (bypass),
    .outValid (outValid),
    .outData  (outData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of one accepted sample, built from R3, R4, R5, R6, R7
  function automatic longint modelStep(input longint x, input bit byp);
    longint s;
    if (byp) begin
      mX = 0;
      mY = 0;
      return x;
    end
    s = ((x - mX) <<< 8) + mY - (mY >>> 11);
    if (s > 64'sd2147483647)   s = 64'sd2147483647;
    if (s < -64'sd2147483648)  s = -64'sd2147483648;
    mX = x;
    mY = s;
    return s >>> 8;
  endfunction

  task automatic sendSample(input logic signed [23:0] x, input bit byp, input string req);
    longint exp;
    inData  = x;
    bypass  = byp;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    exp = modelStep(longint'(x), byp);
    check({req, " outValid"}, longint'(outValid), 1);
    check(req, longint'(outData), exp);
    lastOut = outData;
  endtask

  task automatic idleCycle();
    inData  = 24'($urandom);
    bypass  = 1'($urandom);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle outValid", longint'(outValid), 0);
    check("R8 idle hold", longint'(outData), longint'(lastOut));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    check("R1 reset outValid", longint'(outValid), 0);
    check("R1 reset outData", longint'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset outValid", longint'(outValid), 0);
    check("R1 post-reset outData", longint'(outData), 0);

    // R3/R4: small step from empty memory, then decay
    sendSample(24'sd1000, 1'b0, "R3 first step");
    sendSample(24'sd1000, 1'b0, "R4 floor decay");
    sendSample(-24'sd7, 1'b0, "R4 negative floor");
    idleCycle();
    sendSample(24'sd5, 1'b0, "R8 memory held over idle");

    // R6/R7: bypass passes and clears
    sendSample(24'sd1234567, 1'b1, "R6 bypass pass-through");
    sendSample(-24'sd8388608, 1'b1, "R6 bypass negative limit");
    sendSample(24'sd4321, 1'b0, "R7 first after clear");
    check("R7 output equals input", longint'(outData), 4321);

    // R5: full-scale jump right after a clear saturates
    sendSample(24'sd0, 1'b1, "R7 clear");
    sendSample(-24'sd8388608, 1'b0, "R5 neg full scale");
    sendSample(24'sd8388607, 1'b0, "R5 overflow clamp");
    check("R5 positive limit", longint'(outData), 8388607);
    sendSample(-24'sd8388608, 1'b0, "R5 underflow clamp");
    check("R5 negative limit", longint'(outData), -8388608);

    // R10: mode flips on the same cycle as samples
    sendSample(24'sd300000, 1'b0, "R10 filtered");
    sendSample(24'sd300000, 1'b1, "R10 switch into bypass");
    sendSample(24'sd300000, 1'b0, "R10 switch out of bypass");

    // Random mix: values, modes and gaps
    for (int i = 0; i < 600; i++) begin
      logic signed [23:0] v;
      v = ($urandom % 4 == 0) ? 24'($urandom) : 24'($signed($urandom % 20001) - 10000);
      sendSample(v, ($urandom % 10) == 0, "R3 random");
      if ($urandom % 4 == 0) idleCycle();
    end

    // R9: constant input decays
    sendSample(24'sd0, 1'b1, "R9 clear");
    for (int i = 0; i < 20000; i++) sendSample(24'sd1000000, 1'b0, "R9 stream");
    check("R9 residual below 256", longint'((outData < 0 ? -outData : outData) < 256), 1);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule